// File: doc/BRIEF.md
# Condition Evaluator and Branch Unit

This block handles the branch group of a 32-bit instruction set. It takes the instruction word that is executing, the four program flags (zero, negative, overflow, carry) and one register read value. It evaluates a 4-bit condition against the flags and acts on the result in one of three ways. An absolute branch jumps to a word-aligned constant address. A register-relative branch jumps to a register value plus a scaled signed offset. A set-on-condition instruction writes the boolean result into a register.

A taken branch has one delay slot. The redirect is not raised while the branch itself executes. It is raised while the next valid instruction executes, and the fetch stage then steers to the target. If that slot instruction is also a taken branch, its redirect is held in turn and fires with the instruction after it. In this way each branch keeps its own one-slot delay. Idle cycles, where no valid instruction is present, do not consume the slot.

Top module: `cond_branch_unit`

## Requirements
- R1: The condition code is {word[27:25], word[0]}, so the invert bit sits in bit 0. Codes 0 to 15 mean, in order: always, never, C&~Z, ~C|Z, ~C, C, ~Z, Z, ~V, V, ~N, N, N==V, N!=V, ~Z&(N==V), Z|(N!=V).
- R2: A branch-group word (word[31:28]=4'b1110) with word[1]=0 is an absolute branch. Its target is word[24:2] followed by two zero bits, zero-extended to 32 bits.
- R3: A branch-group word with word[1]=1 and word[24]=1 is a relative branch. Its target is the register named by word[22:18] (index on `rs_idx`, value on `rs_data`) plus four times the signed 14-bit offset in word[15:2].
- R4: A branch-group word with word[1]=1 and word[24]=0 is set-on-condition. In the same cycle it writes 32'd1 if the condition holds, and 32'd0 if not, to register word[22:18]. It never causes a redirect.
- R5: A branch whose condition is false causes no redirect and no register write.
- R6: A taken branch raises `redirect_valid` with its target in the cycle the next valid instruction executes, and never in its own cycle. Cycles with `instr_valid` low keep the pending redirect.
- R7: A taken branch executing in the delay slot of another taken branch gets its own redirect, one valid instruction later, after the first branch's redirect.
- R8: Words outside the branch group cause no write and no redirect, but they still fill a delay slot.
- R9: Reset drops any pending redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction executes this cycle |
| instr | input | 32 | Executing instruction word |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| rs_idx | output | 5 | Register index to read (word[22:18]) |
| rs_data | input | 32 | Value of register `rs_idx` |
| redirect_valid | output | 1 | Steer fetch to `redirect_addr` now |
| redirect_addr | output | 32 | Branch target |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Register written |
| wr_data | output | 32 | Boolean condition result |

## Verification
The pending-redirect register is the only state in the block. A lost pending flag shows up as a missing `redirect_valid` at the very next valid instruction. A stale flag shows up as an extra redirect, and a wrong target register shows up as a wrong `redirect_addr`, in that same cycle. Condition faults appear at once on `wr_data`. For that reason, set-on-condition is swept over all 16 codes and all 16 flag combinations. Back-to-back branches and idle gaps expose any error in slot counting within one or two instructions.

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [31:0]          instr,
  input  logic                 flag_z,
  input  logic                 flag_n,
  input  logic                 flag_v,
  input  logic                 flag_c,
  output logic [REG_IDX_W-1:0] rs_idx,
  input  logic [DATA_W-1:0]    rs_data,
  output logic                 redirect_valid,
  output logic [DATA_W-1:0]    redirect_addr,
  output logic                 wr_en,
  output logic [REG_IDX_W-1:0] wr_idx,
  output logic [DATA_W-1:0]    wr_data
);
  localparam int OFF_W = 14;
  localparam int ABS_W = 25;

  logic              in_grp, is_abs, is_rel, is_set;
  logic [3:0]        cond;
  logic              base_true, cond_true, br_taken;
  logic [DATA_W-1:0] abs_tgt, rel_tgt, cur_tgt;
  logic              pend_q;
  logic [DATA_W-1:0] tgt_q;
  logic              unused_bits;

  assign in_grp = instr[31:28] == 4'b1110;
  assign is_abs = in_grp & ~instr[1];
  assign is_rel = in_grp & instr[1] & instr[24];
  assign is_set = in_grp & instr[1] & ~instr[24];
  assign cond   = {instr[27:25], instr[0]};
  assign rs_idx = instr[18 +: REG_IDX_W];
  assign unused_bits = ^{instr[23], instr[17:16]};

  always_comb begin
    case (cond[3:1])
      3'd0: base_true = 1'b1;
      3'd1: base_true = flag_c & ~flag_z;
      3'd2: base_true = ~flag_c;
      3'd3: base_true = ~flag_z;
      3'd4: base_true = ~flag_v;
      3'd5: base_true = ~flag_n;
      3'd6: base_true = ~(flag_n ^ flag_v);
      default: base_true = ~flag_z & ~(flag_n ^ flag_v);
    endcase
  end
  assign cond_true = base_true ^ cond[0];

  assign abs_tgt = {{(DATA_W-ABS_W){1'b0}}, instr[ABS_W-1:2], 2'b00};
  assign rel_tgt = rs_data + {{(DATA_W-OFF_W-2){instr[OFF_W+1]}}, instr[OFF_W+1:2], 2'b00};
  assign cur_tgt = is_abs ? abs_tgt : rel_tgt;
  assign br_taken = instr_valid & (is_abs | is_rel) & cond_true;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (instr_valid) begin
      pend_q <= br_taken;
      tgt_q  <= cur_tgt;
    end
  end

  assign redirect_valid = instr_valid & pend_q;
  assign redirect_addr  = tgt_q;
  assign wr_en   = instr_valid & is_set;
  assign wr_idx  = rs_idx;
  assign wr_data = {{(DATA_W-1){1'b0}}, cond_true};
endmodule

module cond_branch_unit_chk #(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 instr_valid,
  input logic [31:0]          instr,
  input logic                 br_taken,
  input logic                 pend_q,
  input logic [DATA_W-1:0]    tgt_q,
  input logic                 redirect_valid,
  input logic [DATA_W-1:0]    redirect_addr,
  input logic                 wr_en,
  input logic [REG_IDX_W-1:0] wr_idx,
  input logic [DATA_W-1:0]    wr_data
);
  AST_WRITE_IS_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[DATA_W-1:1] == '0)); // R4
  AST_WRITE_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (instr[31:28] == 4'b1110 && instr[1] && !instr[24] && wr_idx == instr[22:18])); // R4
  AST_REDIRECT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> instr_valid); // R6
  AST_TAKEN_THEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (!instr_valid || redirect_valid)); // R6
  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !instr_valid) |=> (pend_q && $stable(tgt_q))); // R6
  AST_CHAINED_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && br_taken) |=> pend_q); // R7
  AST_IDLE_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!wr_en && !redirect_valid)); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> !pend_q); // R9
  AST_ADDR_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(redirect_addr) || $past(!rst_n)); // R6
endmodule

bind cond_branch_unit cond_branch_unit_chk #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
  .br_taken(br_taken), .pend_q(pend_q), .tgt_q(tgt_q),
  .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/cond_branch_unit_tb.sv
module cond_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr;
  logic        fz, fn, fv, fc;
  logic [4:0]  rs_idx;
  logic [31:0] rs_data;
  logic        redirect_valid;
  logic [31:0] redirect_addr;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;

  int n_checks = 0;
  int n_fail = 0;

  localparam logic [31:0] NOP = 32'h0000_0000;

  always #2 clk = ~clk;

  cond_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .flag_z(fz), .flag_n(fn), .flag_v(fv), .flag_c(fc),
    .rs_idx(rs_idx), .rs_data(rs_data),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  function automatic bit model_cond(input logic [3:0] c, input bit z, n, v, cy);
    case (c)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return cy && !z;
      4'd3:  return !cy || z;
      4'd4:  return !cy;
      4'd5:  return cy;
      4'd6:  return !z;
      4'd7:  return z;
      4'd8:  return !v;
      4'd9:  return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return n == v;
      4'd13: return n != v;
      4'd14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  function automatic logic [31:0] mk_abs(input logic [3:0] c, input logic [24:0] t);
    return {4'hE, c[3:1], t[24:2], 1'b0, c[0]};
  endfunction
  function automatic logic [31:0] mk_rel(input logic [3:0] c, input logic [4:0] r, input logic [13:0] o);
    return {4'hE, c[3:1], 1'b1, 1'b0, r, 2'b00, o, 1'b1, c[0]};
  endfunction
  function automatic logic [31:0] mk_set(input logic [3:0] c, input logic [4:0] r);
    return {4'hE, c[3:1], 1'b0, 1'b0, r, 16'h0000, 1'b1, c[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample 1 time unit later, then let the posedge pass.
  task automatic step(input bit v, input logic [31:0] w);
    @(negedge clk);
    instr_valid = v;
    instr = w;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    instr_valid = 1'b0;
    instr = NOP;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    step(1'b0, NOP);
    check("R9 reset redirect", {31'b0, redirect_valid}, 32'd0);
    check("R9 reset write", {31'b0, wr_en}, 32'd0);
  endtask

  task automatic t_cond_sweep();
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        {fz, fn, fv, fc} = f[3:0];
        step(1'b1, mk_set(c[3:0], 5'd9));
        check("R1 R4 set value", wr_data, {31'b0, model_cond(c[3:0], f[3], f[2], f[1], f[0])});
        check("R4 set strobe", {27'b0, wr_en, wr_idx}, {27'b0, 1'b1, 5'd9});
        check("R4 set no redirect", {31'b0, redirect_valid}, 32'd0);
      end
    end
  endtask

  task automatic t_abs_taken();
    {fz, fn, fv, fc} = 4'b0000;
    step(1'b1, mk_abs(4'd0, 25'h1AB_CDEF));
    check("R6 no redirect in branch cycle", {31'b0, redirect_valid}, 32'd0);
    step(1'b1, NOP);
    check("R6 redirect in slot", {31'b0, redirect_valid}, 32'd1);
    check("R2 absolute target", redirect_addr, 32'h01AB_CDEC);
    step(1'b1, NOP);
    check("R6 single redirect", {31'b0, redirect_valid}, 32'd0);
  endtask

  task automatic t_gap();
    {fz, fn, fv, fc} = 4'b1000;
    step(1'b1, mk_abs(4'd7, 25'h000_0100));
    step(1'b0, NOP);
    check("R6 idle keeps pending", {31'b0, redirect_valid}, 32'd0);
    step(1'b0, NOP);
    step(1'b1, NOP);
    check("R6 redirect after gap", {31'b0, redirect_valid}, 32'd1);
    check("R2 target after gap", redirect_addr, 32'h0000_0100);
  endtask

  task automatic t_relative();
    {fz, fn, fv, fc} = 4'b0000;
    rs_data = 32'h0000_1000;
    step(1'b1, mk_rel(4'd6, 5'd3, 14'h3FFD));
    check("R3 read index", {27'b0, rs_idx}, 32'd3);
    step(1'b1, NOP);
    check("R3 negative offset", redirect_addr, 32'h0000_0FF4);
    check("R3 redirect", {31'b0, redirect_valid}, 32'd1);
    rs_data = 32'h8000_0000;
    step(1'b1, mk_rel(4'd0, 5'd31, 14'h1FFF));
    step(1'b1, NOP);
    check("R3 max positive offset", redirect_addr, 32'h8000_7FFC);
  endtask

  task automatic t_not_taken();
    {fz, fn, fv, fc} = 4'b0000;
    step(1'b1, mk_abs(4'd7, 25'h000_0040));
    check("R5 no write", {31'b0, wr_en}, 32'd0);
    step(1'b1, NOP);
    check("R5 no redirect abs", {31'b0, redirect_valid}, 32'd0);
    step(1'b1, mk_rel(4'd1, 5'd2, 14'h0004));
    step(1'b1, NOP);
    check("R5 no redirect rel", {31'b0, redirect_valid}, 32'd0);
  endtask

  task automatic t_chained();
    {fz, fn, fv, fc} = 4'b0000;
    step(1'b1, mk_abs(4'd0, 25'h000_0A00));
    step(1'b1, mk_abs(4'd0, 25'h000_0B00));
    check("R7 first redirect", {31'b0, redirect_valid}, 32'd1);
    check("R7 first target", redirect_addr, 32'h0000_0A00);
    step(1'b1, NOP);
    check("R7 second redirect", {31'b0, redirect_valid}, 32'd1);
    check("R7 second target", redirect_addr, 32'h0000_0B00);
    step(1'b1, NOP);
    check("R7 queue drained", {31'b0, redirect_valid}, 32'd0);
  endtask

  task automatic t_other_group();
    {fz, fn, fv, fc} = 4'b0000;
    step(1'b1, 32'hC000_0003 | {4'h0, 3'b000, 25'h0});
    check("R8 no write", {31'b0, wr_en}, 32'd0);
    step(1'b1, 32'hF123_4567);
    check("R8 no redirect", {31'b0, redirect_valid}, 32'd0);
    step(1'b1, mk_abs(4'd0, 25'h000_0C00));
    step(1'b1, 32'h6000_0002);
    check("R8 fills slot", {31'b0, redirect_valid}, 32'd1);
    check("R8 slot target", redirect_addr, 32'h0000_0C00);
  endtask

  task automatic t_reset_pending();
    {fz, fn, fv, fc} = 4'b0000;
    step(1'b1, mk_abs(4'd0, 25'h000_0D00));
    do_reset();
    step(1'b1, NOP);
    check("R9 pending dropped", {31'b0, redirect_valid}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    instr_valid = 1'b0;
    instr = NOP;
    {fz, fn, fv, fc} = 4'b0000;
    rs_data = 32'h0;
    do_reset();
    t_reset_state();
    t_cond_sweep();
    t_abs_taken();
    t_gap();
    t_relative();
    t_not_taken();
    t_chained();
    t_other_group();
    t_reset_pending();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule